// File: doc/BRIEF.md
# Fault Retry and Latch-Off Controller

This block decides how a four-output power controller reacts when one of its outputs misbehaves. Analog comparators outside the block raise synchronous fault flags. The block watches for an overvoltage on output 1, overcurrent on outputs 1 and 2, and undervoltage on outputs 3 and 4. It also watches two level flags from the soft-start ramp: one says the ramp has climbed past its high threshold, the other says it has discharged below its low threshold.

Hard faults shut the controller down for good at once. These are overvoltage on output 1 and undervoltage on output 4. Recoverable faults behave differently. They are overcurrent on output 1 or 2 and undervoltage on output 3. Each one inhibits outputs 1 to 3 and bumps a per-domain retry counter. When the ramp has discharged, the block asks for a new soft start. If either counter reaches three faults in a row, the controller shuts down for good. A start-up that completes cleanly empties both counters. Only power-on reset clears the shutdown.

Top module: `fault_retry_ctrl`

## Requirements
- R1: An overvoltage on output 1 while the block is not shut down sets latched_off and inhibit_123 one cycle later. Both counters are left unchanged.
- R2: An undervoltage on output 4 while the block is not shut down sets latched_off and inhibit_123 one cycle later. This holds even while a retry is in progress.
- R3: A recoverable fault seen while inhibit_123 is low sets inhibit_123 one cycle later. Overcurrent on output 2 adds one to count_2. Overcurrent on output 1, undervoltage on output 3, or both together, add exactly one to count_13. If faults from both domains arrive together, both counters step.
- R4: While inhibit_123 is high, recoverable fault flags are not counted. A flag held through the shutdown is therefore counted once.
- R5: restart_req is high, combinationally, in any cycle where all of the following hold: a retry shutdown is active, ramp_low is high, the block is not latched off, and no hard fault is present. inhibit_123 falls on the next cycle.
- R6: A recoverable fault that brings either counter to 3 sets latched_off one cycle later. The counters are plain binary values.
- R7: ramp_high seen while inhibit_123 is low and no fault flag is present clears both counters one cycle later. ramp_high together with a fault, or while inhibit_123 is high, clears nothing.
- R8: Once latched_off is set, it stays set, and inhibit_123 stays high. restart_req stays low. Later fault and ramp flags leave the counters unchanged.
- R9: Power-on reset (por high) clears latched_off, inhibit_123 and both counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, active high, synchronous |
| ov_out1 | input | 1 | Overvoltage on output 1 |
| oc_out1 | input | 1 | Overcurrent on output 1 |
| oc_out2 | input | 1 | Overcurrent on output 2 |
| uv_out3 | input | 1 | Undervoltage on output 3 |
| uv_out4 | input | 1 | Undervoltage on output 4 |
| ramp_high | input | 1 | Soft-start ramp above its high threshold |
| ramp_low | input | 1 | Soft-start ramp below its low threshold |
| inhibit_123 | output | 1 | Disable outputs 1 to 3 |
| latched_off | output | 1 | Permanent shutdown until power-on reset |
| restart_req | output | 1 | Release the soft-start for a retry |
| count_13 | output | CW | Consecutive faults from outputs 1 and 3 |
| count_2 | output | CW | Consecutive faults from output 2 |

## Verification
Recoverable faults are applied one domain at a time, in combination, and held through the inhibit window. This separates per-domain counting from double counting. Retry chains are run both with and without a clean ramp completion in between. This shows whether a success clears the counters and whether three faults in a row latch the block. Hard faults are applied from idle, during a retry, and together with a ramp flag. This confirms that they win over restarts and leave the counters alone. Stimulus after shutdown, followed by a power-on reset, shows that the latch is sticky.

// File: rtl/fault_retry_ctrl.sv
module fault_retry_ctrl #(
  parameter int CW    = 2,
  parameter int LIMIT = 3
) (
  input  logic          clk,
  input  logic          por,
  input  logic          ov_out1,
  input  logic          oc_out1,
  input  logic          oc_out2,
  input  logic          uv_out3,
  input  logic          uv_out4,
  input  logic          ramp_high,
  input  logic          ramp_low,
  output logic          inhibit_123,
  output logic          latched_off,
  output logic          restart_req,
  output logic [CW-1:0] count_13,
  output logic [CW-1:0] count_2
);

  localparam logic [CW-1:0] TOP = CW'(LIMIT);

  logic          latch_q, inh_q;
  logic [CW-1:0] c13_q, c2_q;

  wire hard    = ov_out1 | uv_out4;
  wire soft_13 = oc_out1 | uv_out3;
  wire soft_2  = oc_out2;
  wire armed   = ~latch_q & ~inh_q;
  wire take    = armed & ~hard & (soft_13 | soft_2);
  wire clean   = armed & ramp_high & ~hard & ~soft_13 & ~soft_2;

  wire [CW-1:0] nxt_13 = (take && soft_13 && c13_q != TOP) ? c13_q + 1'b1 : c13_q;
  wire [CW-1:0] nxt_2  = (take && soft_2  && c2_q  != TOP) ? c2_q  + 1'b1 : c2_q;
  wire          hit    = (nxt_13 == TOP) || (nxt_2 == TOP);

  assign restart_req = inh_q & ~latch_q & ramp_low & ~hard;
  assign inhibit_123 = inh_q | latch_q;
  assign latched_off = latch_q;
  assign count_13    = c13_q;
  assign count_2     = c2_q;

  always_ff @(posedge clk) begin
    if (por) begin
      latch_q <= 1'b0;
      inh_q   <= 1'b0;
      c13_q   <= '0;
      c2_q    <= '0;
    end else if (!latch_q) begin
      if (hard || (take && hit)) latch_q <= 1'b1;
      if (take) begin
        inh_q <= 1'b1;
        c13_q <= nxt_13;
        c2_q  <= nxt_2;
      end else if (restart_req) begin
        inh_q <= 1'b0;
      end else if (clean) begin
        c13_q <= '0;
        c2_q  <= '0;
      end
    end
  end

  a_r1_ov_latches: assert property (@(posedge clk) disable iff (por)
    (ov_out1 && !latched_off) |=> (latched_off && inhibit_123));
  a_r2_uv4_latches: assert property (@(posedge clk) disable iff (por)
    (uv_out4 && !latched_off) |=> latched_off);
  a_r1_hard_keeps_counts: assert property (@(posedge clk) disable iff (por)
    (ov_out1 || uv_out4) |=> ($stable(count_13) && $stable(count_2)));
  a_r4_no_recount: assert property (@(posedge clk) disable iff (por)
    inhibit_123 |=> ($stable(count_13) && $stable(count_2)));
  a_r5_restart_releases: assert property (@(posedge clk) disable iff (por)
    restart_req |=> !inhibit_123);
  a_r8_latch_sticky: assert property (@(posedge clk) disable iff (por)
    latched_off |=> (latched_off && inhibit_123 && !restart_req));
  a_r6_limit_latches: assert property (@(posedge clk) disable iff (por)
    (count_13 == TOP || count_2 == TOP) |-> latched_off);

endmodule

// File: tb/fault_retry_ctrl_tb_top.sv
module fault_retry_ctrl_tb_top;
  logic clk = 1'b0;
  logic por = 1'b1;
  logic ov1 = 0, oc1 = 0, oc2 = 0, uv3 = 0, uv4 = 0, rhi = 0, rlo = 0;
  logic inh, sd, rr;
  logic [1:0] c13, c2;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fault_retry_ctrl #(.CW(2), .LIMIT(3)) dut_i (
    .clk(clk), .por(por), .ov_out1(ov1), .oc_out1(oc1), .oc_out2(oc2),
    .uv_out3(uv3), .uv_out4(uv4), .ramp_high(rhi), .ramp_low(rlo),
    .inhibit_123(inh), .latched_off(sd), .restart_req(rr),
    .count_13(c13), .count_2(c2));

  // {ov1,oc1,oc2,uv3,uv4,rhi,rlo} rr {inh,sd,c13,c2}
  localparam logic [13:0] VEC [15] = '{
    14'b0100000_0_100100, 14'b0100000_0_100100, 14'b0000001_1_000100,
    14'b0000000_0_000100, 14'b0010000_0_100101, 14'b0000001_1_000101,
    14'b0000010_0_000000, 14'b0001000_0_100100, 14'b0000001_1_000100,
    14'b0101000_0_101000, 14'b0000001_1_001000, 14'b0110000_0_111101,
    14'b0010000_0_111101, 14'b0000001_0_111101, 14'b0000010_0_111101};
  string TAGS [15] = '{"R3", "R4", "R5", "R5", "R3", "R5", "R7", "R3",
                       "R5", "R3", "R5", "R6", "R8", "R8", "R8"};

  task automatic chk(input string tag, input logic [5:0] got, input logic [5:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic step(input logic [6:0] in, input logic exp_rr,
                      input logic [5:0] exp, input string tag);
    {ov1, oc1, oc2, uv3, uv4, rhi, rlo} = in;
    #1;
    chk({tag, " restart_req"}, {5'b0, rr}, {5'b0, exp_rr});
    @(posedge clk);
    @(negedge clk);
    chk(tag, {inh, sd, c13, c2}, exp);
  endtask

  task automatic do_por();
    {ov1, oc1, oc2, uv3, uv4, rhi, rlo} = '0;
    por = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    por = 1'b0;
  endtask

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          total++; bad++;
          $display("FAIL watchdog: got timeout expected completion");
          $display("test done: total=%0d bad=%0d", total, bad);
          $finish;
        end
      end
    join_none

    do_por();
    chk("R9 reset state", {inh, sd, c13, c2}, 6'b000000);

    for (int i = 0; i < 15; i++)
      step(VEC[i][13:7], VEC[i][6], VEC[i][5:0], TAGS[i]);

    do_por();
    chk("R9 por clears latch", {inh, sd, c13, c2}, 6'b000000);
    step(7'b1000000, 1'b0, 6'b110000, "R1 ov from idle");
    do_por();
    step(7'b0000100, 1'b0, 6'b110000, "R2 uv4 from idle");
    do_por();
    step(7'b0010000, 1'b0, 6'b100001, "R3 oc2 first");
    step(7'b0000001, 1'b1, 6'b000001, "R5 restart");
    step(7'b0010000, 1'b0, 6'b100010, "R3 oc2 second");
    step(7'b0000001, 1'b1, 6'b000010, "R5 restart");
    step(7'b0010000, 1'b0, 6'b110011, "R6 oc2 third latches");
    do_por();
    step(7'b0100000, 1'b0, 6'b100100, "R3 oc1");
    step(7'b1000000, 1'b0, 6'b110100, "R1 ov during retry");
    do_por();
    step(7'b0100010, 1'b0, 6'b100100, "R7 fault beats clear");
    step(7'b0000010, 1'b0, 6'b100100, "R7 no clear while inhibited");
    step(7'b0000101, 1'b0, 6'b110100, "R2 uv4 blocks restart");
    step(7'b0000001, 1'b0, 6'b110100, "R8 no restart after latch");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule